// File: doc/BRIEF.md
# Keyed Write-Protection and Event-Response Guard

This block guards the register bank of a cryptographic engine. A mode register selects, separately, whether writes to the configuration group, the interrupt group and the control register are refused. The three protect bits change only when the same write carries a 24-bit password. Every bus write is classified by its word address. A write that hits a protected group is dropped, raises the write-protect violation event and records the address it aimed at. All other writes to the bank are forwarded to the register file.

Five abnormal events are collected into sticky flags: private-key access violation, write-protect violation, clock glitch, sequence error and software control error. The action field of the mode register picks a response for one class of these events or for all of them. It can only report. It can block new engine starts until an unlock command arrives. It can also block starts and, in the same cycle, wipe the stored key. An operation already running is never interrupted. Error logging keeps either the first or the most recent violation source and software-error type, and a summary interrupt marks an open error series until software reads the status register.

Top module: `wpg_guard_top`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 0, the summary interrupt is low and no lock is active.
- R2: A write to the mode word (index 57) always updates action (bits 7:5) and first-only (bit 4). It changes the control (bit 2), interrupt (bit 1) and configuration (bit 0) protect bits only when bits 31:8 equal 0x414553. Bits 31:8 and bit 3 always read as 0.
- R3: A write to a protected register does not reach the forward strobe. It sets status flag bit 1 and records its word index in status bits 13:8. An external write-protect event with no internal violation in the same cycle records all ones. An unprotected write is forwarded in the same cycle.
- R4: Word indices 0 to 15 belong to the configuration group, 16 to 19 to the interrupt group, and 20 is the control register. Any other index is never protected.
- R5: Action values 0 and 7 never lock and never wipe the key, whatever the event.
- R6: Event bits are 0 private key, 1 write protect, 2 glitch, 3 sequence, 4 software error. Actions 1 and 4 respond to bits 0, 1 and 4. Actions 2 and 5 respond to bits 2 and 3. Actions 3 and 6 respond to all five. A responding event blocks the start strobe from the cycle it occurs in.
- R7: The unlock input releases the lock at the next clock edge. An event that responds in that same cycle keeps the lock set.
- R8: Actions 4, 5 and 6 raise the key-wipe output in the same cycle as a responding event.
- R9: With first-only at 0, the source field and the software error type (status bits 19:16) hold the most recent error. With first-only at 1, they hold the first one of the series.
- R10: Status flags (bits 4:0) and the summary interrupt set in the cycle after any event. A status read returns the flags and then clears them, which ends the series. An event in the same cycle as the read starts a new series holding only that event.
- R11: The start strobe equals the start request while the engine is idle and no lock is active, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data for mode or status word, else 0 |
| wr_fwd_o | output | 1 | Write accepted and forwarded to the register file |
| ev_i | input | 5 | Event detect pulses (bit order in R6) |
| swe_typ_i | input | 4 | Software error type, valid with ev_i bit 4 |
| unlock_i | input | 1 | Unlock command |
| eng_busy_i | input | 1 | Engine is processing |
| start_req_i | input | 1 | Request to start a new operation |
| start_o | output | 1 | Start strobe to the engine |
| key_wipe_o | output | 1 | Clear the stored key words |
| sec_irq_o | output | 1 | Summary security-error interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first is a status read that clears the flags and a new event that sets one. The bench raises a sequence-error pulse in the same cycle as a status read. It expects the read to return only the earlier glitch flag and a second read to show only the sequence flag. The second pair is an unlock command and a responding event. The bench drives both in one cycle and judges that the start strobe stays blocked until a later unlock.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam logic [23:0] WPG_PASSKEY = 24'h414553;
    localparam int          WPG_EV_N    = 5;

    localparam int EV_PKEY  = 0;
    localparam int EV_WPV   = 1;
    localparam int EV_GLT   = 2;
    localparam int EV_SEQ   = 3;
    localparam int EV_SWERR = 4;

    localparam logic [WPG_EV_N-1:0] CLASS_ACCESS = 5'b10011;
    localparam logic [WPG_EV_N-1:0] CLASS_PHYS   = 5'b01100;

    typedef enum logic [2:0] {
        ACT_REPORT    = 3'd0,
        ACT_LOCK_ACC  = 3'd1,
        ACT_LOCK_PHY  = 3'd2,
        ACT_LOCK_ALL  = 3'd3,
        ACT_WIPE_ACC  = 3'd4,
        ACT_WIPE_PHY  = 3'd5,
        ACT_WIPE_ALL  = 3'd6,
        ACT_SPARE     = 3'd7
    } wpg_action_e;

    typedef struct packed {
        wpg_action_e action;
        logic        first_only;
        logic        prot_ctrl;
        logic        prot_irq;
        logic        prot_cfg;
    } wpg_mode_t;

    function automatic logic [WPG_EV_N-1:0] wpg_resp_mask(input wpg_action_e a);
        case (a)
            ACT_LOCK_ACC, ACT_WIPE_ACC: wpg_resp_mask = CLASS_ACCESS;
            ACT_LOCK_PHY, ACT_WIPE_PHY: wpg_resp_mask = CLASS_PHYS;
            ACT_LOCK_ALL, ACT_WIPE_ALL: wpg_resp_mask = CLASS_ACCESS | CLASS_PHYS;
            default:                    wpg_resp_mask = '0;
        endcase
    endfunction

    function automatic logic wpg_wipes(input wpg_action_e a);
        wpg_wipes = (a == ACT_WIPE_ACC) || (a == ACT_WIPE_PHY) || (a == ACT_WIPE_ALL);
    endfunction

    function automatic logic [31:0] wpg_mode_word(input wpg_mode_t m);
        wpg_mode_word = {24'h0, m.action, m.first_only, 1'b0,
                         m.prot_ctrl, m.prot_irq, m.prot_cfg};
    endfunction

endpackage

// File: rtl/wpg_mode_reg.sv
module wpg_mode_reg
    import wpg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int MODE_IDX = 57
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output wpg_mode_t         mode_o
);
    logic hit;
    logic key_ok;
    logic unused_bit3;
    wpg_mode_t mode_q;

    assign hit         = wen && (32'(addr) == MODE_IDX);
    assign key_ok      = (wdata[31:8] == WPG_PASSKEY);
    assign unused_bit3 = wdata[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (hit) begin
            mode_q.action     <= wpg_action_e'(wdata[7:5]);
            mode_q.first_only <= wdata[4];
            if (key_ok) begin
                mode_q.prot_ctrl <= wdata[2];
                mode_q.prot_irq  <= wdata[1];
                mode_q.prot_cfg  <= wdata[0];
            end
        end
    end

    assign mode_o = mode_q;

    // R2
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !key_ok) |=> ($stable(mode_q.prot_ctrl) && $stable(mode_q.prot_irq)
                              && $stable(mode_q.prot_cfg)));

endmodule

// File: rtl/wpg_wr_filter.sv
module wpg_wr_filter
    import wpg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int CFG_BASE = 0,
    parameter int CFG_CNT  = 16,
    parameter int IRQ_BASE = 16,
    parameter int IRQ_CNT  = 4,
    parameter int CTRL_IDX = 20,
    parameter int MODE_IDX = 57,
    parameter int STAT_IDX = 58
) (
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  wpg_mode_t         mode,
    output logic              viol_o,
    output logic              fwd_o
);
    localparam int N_GRP = 3;

    int               ai;
    logic [N_GRP-1:0] in_grp;
    logic [N_GRP-1:0] grp_en;
    logic             own_reg;

    assign ai     = 32'(addr);
    assign grp_en = {mode.prot_ctrl, mode.prot_irq, mode.prot_cfg};

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int LO  = (g == 0) ? CFG_BASE : (g == 1) ? IRQ_BASE : CTRL_IDX;
        localparam int CNT = (g == 0) ? CFG_CNT  : (g == 1) ? IRQ_CNT  : 1;
        assign in_grp[g] = (ai >= LO) && (ai < LO + CNT);
    end

    assign own_reg = (ai == MODE_IDX) || (ai == STAT_IDX);
    assign viol_o  = wen && |(in_grp & grp_en);
    assign fwd_o   = wen && !viol_o && !own_reg;

endmodule

// File: rtl/wpg_event_policy.sv
module wpg_event_policy
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SWT_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  wpg_mode_t           mode,
    input  logic [WPG_EV_N-1:0] ev,
    input  logic                int_viol,
    input  logic [ADDR_W-1:0]   viol_addr,
    input  logic [SWT_W-1:0]    swe_typ,
    input  logic                stat_rd,
    input  logic                unlock,
    output logic                lock_now_o,
    output logic                key_wipe_o,
    output logic [WPG_EV_N-1:0] flags_o,
    output logic [ADDR_W-1:0]   src_o,
    output logic [SWT_W-1:0]    typ_o,
    output logic                irq_o
);
    logic [WPG_EV_N-1:0] flag_q;
    logic [WPG_EV_N-1:0] flag_base;
    logic [ADDR_W-1:0]   src_q;
    logic [SWT_W-1:0]    typ_q;
    logic                irq_q;
    logic                lock_q;
    logic                hit;
    logic                take_src;
    logic                take_typ;

    assign flag_base = stat_rd ? '0 : flag_q;

    for (genvar i = 0; i < WPG_EV_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= flag_base[i] | ev[i];
        end
    end

    assign take_src = ev[EV_WPV]   && (!mode.first_only || !flag_base[EV_WPV]);
    assign take_typ = ev[EV_SWERR] && (!mode.first_only || !flag_base[EV_SWERR]);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            typ_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (take_src) src_q <= int_viol ? viol_addr : '1;
            if (take_typ) typ_q <= swe_typ;
            irq_q <= (stat_rd ? 1'b0 : irq_q) | (|ev);
        end
    end

    assign hit = |(ev & wpg_resp_mask(mode.action));

    always_ff @(posedge clk) begin
        if (rst)         lock_q <= 1'b0;
        else if (hit)    lock_q <= 1'b1;
        else if (unlock) lock_q <= 1'b0;
    end

    assign lock_now_o = lock_q | hit;
    assign key_wipe_o = hit && wpg_wipes(mode.action);
    assign flags_o    = flag_q;
    assign src_o      = src_q;
    assign typ_o      = typ_q;
    assign irq_o      = irq_q;

    // R5
    passive_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.action == ACT_REPORT || mode.action == ACT_SPARE) |-> !key_wipe_o);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(|ev));

    // R9
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.first_only && flag_q[EV_SWERR] && !stat_rd) |=> $stable(typ_q));

    // R7
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (unlock && !(|ev)) |=> !lock_q);

endmodule

// File: rtl/wpg_guard_top.sv
module wpg_guard_top
    import wpg_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SWT_W    = 4,
    parameter int CFG_BASE = 0,
    parameter int CFG_CNT  = 16,
    parameter int IRQ_BASE = 16,
    parameter int IRQ_CNT  = 4,
    parameter int CTRL_IDX = 20,
    parameter int MODE_IDX = 57,
    parameter int STAT_IDX = 58
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wen,
    input  logic              bus_ren,
    output logic [31:0]       bus_rdata,
    output logic              wr_fwd_o,
    input  logic [4:0]        ev_i,
    input  logic [SWT_W-1:0]  swe_typ_i,
    input  logic              unlock_i,
    input  logic              eng_busy_i,
    input  logic              start_req_i,
    output logic              start_o,
    output logic              key_wipe_o,
    output logic              sec_irq_o
);
    localparam int SRC_LSB = 8;
    localparam int TYP_LSB = 16;

    wpg_mode_t           mode;
    logic                viol;
    logic                stat_rd;
    logic                lock_now;
    logic [WPG_EV_N-1:0] ev_all;
    logic [WPG_EV_N-1:0] flags;
    logic [ADDR_W-1:0]   src;
    logic [SWT_W-1:0]    typ;

    wpg_mode_reg #(.ADDR_W(ADDR_W), .MODE_IDX(MODE_IDX)) mode_i (
        .clk(clk), .rst(rst), .wen(bus_wen), .addr(bus_addr),
        .wdata(bus_wdata), .mode_o(mode)
    );

    wpg_wr_filter #(
        .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .CFG_CNT(CFG_CNT),
        .IRQ_BASE(IRQ_BASE), .IRQ_CNT(IRQ_CNT), .CTRL_IDX(CTRL_IDX),
        .MODE_IDX(MODE_IDX), .STAT_IDX(STAT_IDX)
    ) filt_i (
        .wen(bus_wen), .addr(bus_addr), .mode(mode),
        .viol_o(viol), .fwd_o(wr_fwd_o)
    );

    always_comb begin
        ev_all         = ev_i;
        ev_all[EV_WPV] = ev_i[EV_WPV] | viol;
    end

    assign stat_rd = bus_ren && (32'(bus_addr) == STAT_IDX);

    wpg_event_policy #(.ADDR_W(ADDR_W), .SWT_W(SWT_W)) pol_i (
        .clk(clk), .rst(rst), .mode(mode), .ev(ev_all),
        .int_viol(viol), .viol_addr(bus_addr), .swe_typ(swe_typ_i),
        .stat_rd(stat_rd), .unlock(unlock_i),
        .lock_now_o(lock_now), .key_wipe_o(key_wipe_o),
        .flags_o(flags), .src_o(src), .typ_o(typ), .irq_o(sec_irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_ren) begin
            if (32'(bus_addr) == MODE_IDX) begin
                bus_rdata = wpg_mode_word(mode);
            end else if (stat_rd) begin
                bus_rdata[WPG_EV_N-1:0]            = flags;
                bus_rdata[SRC_LSB +: ADDR_W]       = src;
                bus_rdata[TYP_LSB +: SWT_W]        = typ;
            end
        end
    end

    assign start_o = start_req_i && !eng_busy_i && !lock_now;

    // R11
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_now || eng_busy_i) |-> !start_o);

    // R3
    drop_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> (!wr_fwd_o && ev_all[EV_WPV]));

    // R8
    wipe_lock_chk: assert property (@(posedge clk) disable iff (rst)
        key_wipe_o |=> !start_o || unlock_i);

endmodule

// File: tb/wpg_guard_top_tb.sv
module wpg_guard_top_tb_top;
    localparam int CLK_P = 10;
    localparam logic [31:0] PASS = 32'h41455300;
    localparam logic [5:0] MODE_A = 6'd57;
    localparam logic [5:0] STAT_A = 6'd58;

    logic clk = 0, rst = 1;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_wen = 0, bus_ren = 0;
    logic [31:0] bus_rdata;
    logic wr_fwd_o;
    logic [4:0] ev_i = '0;
    logic [3:0] swe_typ_i = '0;
    logic unlock_i = 0, eng_busy_i = 0, start_req_i = 0;
    logic start_o, key_wipe_o, sec_irq_o;

    int n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    wpg_guard_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
        .wr_fwd_o(wr_fwd_o), .ev_i(ev_i), .swe_typ_i(swe_typ_i),
        .unlock_i(unlock_i), .eng_busy_i(eng_busy_i), .start_req_i(start_req_i),
        .start_o(start_o), .key_wipe_o(key_wipe_o), .sec_irq_o(sec_irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1;
        tick();
        bus_wen = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a; bus_ren = 1;
        #1 v = bus_rdata;
        tick();
        bus_ren = 0;
    endtask

    function automatic logic responds(input int act, input int e);
        case (act)
            1, 4: responds = (e == 0) || (e == 1) || (e == 4);
            2, 5: responds = (e == 2) || (e == 3);
            3, 6: responds = 1'b1;
            default: responds = 1'b0;
        endcase
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        prot;
        repeat (2) tick();
        rst = 0;
        tick();

        // R1 reset state
        rd(MODE_A, v); check("R1 mode", v, 0);
        rd(STAT_A, v); check("R1 status", v, 0);
        check("R1 irq", 32'(sec_irq_o), 0);
        start_req_i = 1; #1 check("R1 start free", 32'(start_o), 1); start_req_i = 0;

        // R2 key gating
        wr(MODE_A, 32'h414554F7);
        rd(MODE_A, v); check("R2 bad key", v, 32'h000000F0);
        wr(MODE_A, PASS | 32'h0F);
        rd(MODE_A, v); check("R2 good key", v, 32'h00000007);
        wr(MODE_A, 32'h00000000);
        rd(MODE_A, v); check("R2 bad key hold", v, 32'h00000007);

        // R3 R4 sweep over protect patterns and addresses
        for (int p = 0; p < 8; p++) begin
            wr(MODE_A, PASS | 32'(p));
            rd(STAT_A, v);
            for (int a = 0; a < 24; a++) begin
                prot = (a < 16 && p[0]) || (a >= 16 && a < 20 && p[1]) || (a == 20 && p[2]);
                bus_addr = 6'(a); bus_wdata = 32'hA5A5_0000 | 32'(a); bus_wen = 1;
                #1 check("R4 forward", 32'(wr_fwd_o), 32'(!prot));
                tick();
                bus_wen = 0;
                rd(STAT_A, v);
                check("R3 wpv flag", 32'(v[1]), 32'(prot));
                if (prot) check("R3 source", 32'(v[13:8]), 32'(a));
            end
        end
        rd(STAT_A, v);

        // R3 external wpv records all ones
        wr(MODE_A, PASS);
        ev_i = 5'b00010; tick(); ev_i = 0;
        rd(STAT_A, v); check("R3 ext source", 32'(v[13:8]), 32'h3F);

        // R5 R6 R8 R7 action x event sweep
        start_req_i = 1;
        for (int act = 0; act < 8; act++) begin
            for (int e = 0; e < 5; e++) begin
                wr(MODE_A, PASS | 32'(act << 5));
                ev_i = 5'(1 << e);
                #1;
                check("R6 start same cycle", 32'(start_o), 32'(!responds(act, e)));
                check("R8 R5 wipe", 32'(key_wipe_o),
                      32'(responds(act, e) && act >= 4 && act <= 6));
                tick();
                ev_i = 0;
                #1 check("R6 lock held", 32'(start_o), 32'(!responds(act, e)));
                unlock_i = 1; tick(); unlock_i = 0;
                #1 check("R7 released", 32'(start_o), 1);
                rd(STAT_A, v);
            end
        end

        // R7 unlock and event in one cycle
        wr(MODE_A, PASS | 32'(3 << 5));
        ev_i = 5'b00100; unlock_i = 1; tick(); ev_i = 0; unlock_i = 0;
        #1 check("R7 event beats unlock", 32'(start_o), 0);
        unlock_i = 1; tick(); unlock_i = 0;
        #1 check("R7 later unlock", 32'(start_o), 1);
        rd(STAT_A, v);

        // R11 busy blocks start
        wr(MODE_A, PASS);
        eng_busy_i = 1; #1 check("R11 busy", 32'(start_o), 0);
        eng_busy_i = 0; #1 check("R11 idle", 32'(start_o), 1);
        start_req_i = 0; #1 check("R11 no req", 32'(start_o), 0);

        // R9 first vs last logging
        for (int f = 0; f < 2; f++) begin
            wr(MODE_A, PASS | 32'(f << 4) | 32'h1);
            rd(STAT_A, v);
            wr(6'd2, 0);
            wr(6'd5, 0);
            ev_i = 5'b10000; swe_typ_i = 4'd3; tick();
            swe_typ_i = 4'd9; tick();
            ev_i = 0; swe_typ_i = 0;
            rd(STAT_A, v);
            check("R9 source", 32'(v[13:8]), (f != 0) ? 2 : 5);
            check("R9 sw type", 32'(v[19:16]), (f != 0) ? 3 : 9);
        end
        wr(6'd7, 0);
        rd(STAT_A, v); check("R9 new series", 32'(v[13:8]), 7);

        // R10 series and read/event collision
        ev_i = 5'b00100; tick(); ev_i = 0;
        check("R10 irq set", 32'(sec_irq_o), 1);
        bus_addr = STAT_A; bus_ren = 1; ev_i = 5'b01000;
        #1 check("R10 read old flags", 32'(bus_rdata[4:0]), 32'h04);
        tick();
        bus_ren = 0; ev_i = 0;
        check("R10 irq new series", 32'(sec_irq_o), 1);
        rd(STAT_A, v); check("R10 new only", 32'(v[4:0]), 32'h08);
        check("R10 irq cleared", 32'(sec_irq_o), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule